// File: doc/BRIEF.md
# Batched Translation-Cache Invalidation Unit

This block holds a small fully associative address-translation cache and a queue of pending fine-grained invalidations. Each cache entry carries a virtual page number, an address-space identifier, a virtual-machine identifier and a global flag. A core sends memory-management operations over a valid/ready channel. Each operation carries an operation code, an address operand and an identifier operand, and each operand has a flag that marks it as the zero register.

Fine-grained invalidations go into the queue and are accepted without a stall while the queue has room. The queue then applies them to the cache in the background, one per cycle. Stalls come only from two split fences. The first fence waits for the store buffer to drain. The second fence waits for the invalidation queue to empty. A conventional full fence waits for both conditions and then applies its own invalidation. The sequence "wait for stores, one or more queued invalidations, wait for invalidations" leaves the cache in the same state as one full fence with the same operands.

A fill port writes entries on behalf of an external page walker. A lookup port serves implicit references and returns a registered hit and entry index.

Top module: `xlat_inval_unit`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and the invalidation queue is empty. A wait-for-invalidations operation (code 5) is accepted at once.
- R2: A lookup asserted in one cycle gives its result in the next cycle. The result is a hit when a valid entry has an equal page number and an equal VMID, and its ASID is equal or the entry is global. `lk_idx` gives the lowest matching index. When no lookup is requested, `lk_hit` is 0.
- R3: Codes 1 (address-space invalidate) and 2 (guest address-space invalidate) remove every valid entry where two conditions hold. First, the address operand is zero-flagged or equals the page number. Second, the identifier operand is zero-flagged, or it equals the entry ASID and the entry is not global.
- R4: Code 3 (guest-physical invalidate) removes every valid entry where two conditions hold. First, the address is zero-flagged or matches the page number. Second, the identifier is zero-flagged or equals the entry VMID. The global flag does not protect an entry from this code.
- R5: An invalidation (codes 1 to 3) is accepted in any cycle in which the queue holds fewer than QDEPTH (4) entries. When the queue holds QDEPTH entries, ready is low for these codes.
- R6: The queue applies at most one invalidation per cycle, oldest first. It does not apply one in a cycle in which the fill port writes. A lookup sees the cache as it was before the invalidation applied in the same cycle.
- R7: A wait-for-stores operation (code 4) is accepted only in a cycle with `sb_empty` high.
- R8: A wait-for-invalidations operation (code 5) is accepted only when the queue is empty. After it is accepted, no lookup hits an entry that an earlier queued invalidation removed.
- R9: A full fence (code 0) is accepted only when `sb_empty` is high, the queue is empty and no fill is in progress. On acceptance it removes entries by the rule of R3.
- R10: Codes 6 and 7 are accepted at once and change no cache entry.
- R11: A fill writes the page number, ASID, VMID and global flag into the entry at `fill_idx` and marks that entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when high with in_valid |
| in_op | input | 3 | Operation code (0 full fence, 1 to 3 invalidations, 4 wait stores, 5 wait invalidations) |
| in_addr | input | VPN_W | Address operand (page number) |
| in_addr_zero | input | 1 | Address operand is the zero register: all addresses |
| in_id | input | ID_W | ASID or VMID operand |
| in_id_zero | input | 1 | Identifier operand is the zero register: all spaces |
| sb_empty | input | 1 | Store buffer holds no earlier stores |
| fill_en | input | 1 | Write an entry this cycle |
| fill_idx | input | IDX_W | Entry to write |
| fill_vpn | input | VPN_W | Page number to write |
| fill_asid | input | ID_W | ASID to write |
| fill_vmid | input | ID_W | VMID to write |
| fill_global | input | 1 | Global flag to write |
| lk_en | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ID_W | Lookup ASID |
| lk_vmid | input | ID_W | Lookup VMID |
| lk_hit | output | 1 | Registered lookup hit |
| lk_idx | output | IDX_W | Registered index of the hit entry |

## Verification
The assertions assume that the operation operands stay stable while `in_valid` waits for ready. They also assume that `in_op` holds a defined 3-bit code in any cycle in which `in_valid` is high. The bench drives inputs only just after a clock edge and keeps an offered operation unchanged until a negative-edge sample shows ready. It holds the fill port busy for several cycles so that the queue reaches its full state. It drives the store-buffer flag low and then releases it from a separate process while a fence waits.

// File: rtl/xinv_pkg.sv
package xinv_pkg;

  typedef enum logic [2:0] {
    OP_FULL_FENCE  = 3'd0,
    OP_INV_ASID    = 3'd1,
    OP_INV_GUEST   = 3'd2,
    OP_INV_VMID    = 3'd3,
    OP_WAIT_STORES = 3'd4,
    OP_WAIT_INVALS = 3'd5
  } xinv_op_e;

  function automatic logic op_is_inval(input logic [2:0] op);
    return (op == OP_INV_ASID) || (op == OP_INV_GUEST) || (op == OP_INV_VMID);
  endfunction

endpackage

// File: rtl/xinv_queue.sv
module xinv_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/xinv_array.sv
module xinv_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ID_W    = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ID_W-1:0]  fill_asid,
  input  logic [ID_W-1:0]  fill_vmid,
  input  logic             fill_global,
  input  logic             kill_en,
  input  logic             kill_by_vmid,
  input  logic             kill_addr_zero,
  input  logic [VPN_W-1:0] kill_addr,
  input  logic             kill_id_zero,
  input  logic [ID_W-1:0]  kill_id,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ID_W-1:0]  lk_asid,
  input  logic [ID_W-1:0]  lk_vmid,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx
);

  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ID_W-1:0]    e_asid [ENTRIES];
  logic [ID_W-1:0]    e_vmid [ENTRIES];
  logic [ENTRIES-1:0] e_glb;
  logic [ENTRIES-1:0] kill_vec, hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic addr_ok, id_ok;
    assign addr_ok = kill_addr_zero || (e_vpn[i] == kill_addr);
    assign id_ok   = kill_id_zero ||
                     (kill_by_vmid ? (e_vmid[i] == kill_id)
                                   : ((e_asid[i] == kill_id) && !e_glb[i]));
    assign kill_vec[i] = valid[i] && addr_ok && id_ok;
    assign hit_vec[i]  = valid[i] && (e_vpn[i] == lk_vpn) &&
                         (e_vmid[i] == lk_vmid) &&
                         (e_glb[i] || (e_asid[i] == lk_asid));

    always_ff @(posedge clk) begin
      if (fill_en && fill_idx == IDX_W'(i)) begin
        e_vpn[i]  <= fill_vpn;
        e_asid[i] <= fill_asid;
        e_vmid[i] <= fill_vmid;
        e_glb[i]  <= fill_global;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                                   valid[i] <= 1'b0;
      else if (fill_en && fill_idx == IDX_W'(i)) valid[i] <= 1'b1;
      else if (kill_en && kill_vec[i])           valid[i] <= 1'b0;
    end
  end

  logic             found;
  logic [IDX_W-1:0] found_idx;

  always_comb begin
    found     = 1'b0;
    found_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found     = 1'b1;
        found_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit <= 1'b0;
      lk_idx <= '0;
    end else begin
      lk_hit <= lk_en && found;
      if (lk_en && found) lk_idx <= found_idx;
    end
  end

endmodule

// File: rtl/xlat_inval_unit.sv
module xlat_inval_unit
  import xinv_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int QDEPTH  = 4,
  parameter int VPN_W   = 20,
  parameter int ID_W    = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [VPN_W-1:0] in_addr,
  input  logic             in_addr_zero,
  input  logic [ID_W-1:0]  in_id,
  input  logic             in_id_zero,
  input  logic             sb_empty,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ID_W-1:0]  fill_asid,
  input  logic [ID_W-1:0]  fill_vmid,
  input  logic             fill_global,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ID_W-1:0]  lk_asid,
  input  logic [ID_W-1:0]  lk_vmid,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx
);

  localparam int PW    = 3 + VPN_W + ID_W;
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic [PW-1:0]    q_in, q_head;
  logic [CNT_W-1:0] q_count;
  logic             q_empty, q_full, q_push, q_pop;
  logic             full_go;

  always_comb begin
    unique case (in_op)
      OP_FULL_FENCE:                       in_ready = sb_empty && q_empty && !fill_en;
      OP_INV_ASID, OP_INV_GUEST, OP_INV_VMID: in_ready = !q_full;
      OP_WAIT_STORES:                      in_ready = sb_empty;
      OP_WAIT_INVALS:                      in_ready = q_empty;
      default:                             in_ready = 1'b1;
    endcase
  end

  assign q_push  = in_valid && in_ready && op_is_inval(in_op);
  assign q_pop   = !q_empty && !fill_en;
  assign full_go = in_valid && in_ready && (in_op == OP_FULL_FENCE);
  assign q_in    = {in_op == OP_INV_VMID, in_addr_zero, in_addr, in_id_zero, in_id};

  xinv_queue #(.W(PW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .push_data(q_in), .pop(q_pop),
    .head(q_head), .count(q_count), .empty(q_empty), .full(q_full)
  );

  logic             k_vmid, k_az, k_iz;
  logic [VPN_W-1:0] k_addr;
  logic [ID_W-1:0]  k_id;

  always_comb begin
    if (full_go) begin
      k_vmid = 1'b0;
      k_az   = in_addr_zero;
      k_addr = in_addr;
      k_iz   = in_id_zero;
      k_id   = in_id;
    end else begin
      {k_vmid, k_az, k_addr, k_iz, k_id} = q_head;
    end
  end

  xinv_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ID_W(ID_W)) u_array (
    .clk(clk), .rst(rst),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_vmid(fill_vmid), .fill_global(fill_global),
    .kill_en(q_pop || full_go), .kill_by_vmid(k_vmid), .kill_addr_zero(k_az),
    .kill_addr(k_addr), .kill_id_zero(k_iz), .kill_id(k_id),
    .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_vmid(lk_vmid),
    .lk_hit(lk_hit), .lk_idx(lk_idx)
  );

endmodule

// File: rtl/xinv_checker.sv
module xinv_checker
  import xinv_pkg::*;
#(
  parameter int QDEPTH = 4,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic             sb_empty,
  input logic             fill_en,
  input logic             lk_hit,
  input logic [CNT_W-1:0] q_count
);

  logic accepted_inval;
  assign accepted_inval = in_valid && in_ready && op_is_inval(in_op);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  a_r5_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_is_inval(in_op) && q_count == CNT_W'(QDEPTH)) |-> !in_ready);

  a_r5_room_accepts: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_is_inval(in_op) && q_count < CNT_W'(QDEPTH)) |-> in_ready);

  a_r6_hold_on_fill: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !accepted_inval) |=> q_count == $past(q_count));

  a_r6_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
    (!fill_en && q_count != '0 && !accepted_inval) |=> q_count == $past(q_count) - 1'b1);

  a_r7_wait_stores: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_WAIT_STORES && !sb_empty) |-> !in_ready);

  a_r8_wait_invals: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_WAIT_INVALS && q_count != '0) |-> !in_ready);

  a_r9_full_fence_waits: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_FULL_FENCE && (!sb_empty || q_count != '0 || fill_en))
      |-> !in_ready);

endmodule

bind xlat_inval_unit xinv_checker #(.QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .sb_empty(sb_empty), .fill_en(fill_en), .lk_hit(lk_hit), .q_count(q_count)
);

// File: tb/xlat_inval_unit_test.sv
`timescale 1ns/1ps
module xlat_inval_unit_test;
  localparam int ENTRIES = 8, QDEPTH = 4, VPN_W = 20, ID_W = 8, IDX_W = 3;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, in_addr_zero = 0, in_id_zero = 0, sb_empty = 1;
  logic [2:0] in_op = 0;
  logic [VPN_W-1:0] in_addr = 0, fill_vpn = 0, lk_vpn = 0;
  logic [ID_W-1:0] in_id = 0, fill_asid = 0, fill_vmid = 0, lk_asid = 0, lk_vmid = 0;
  logic fill_en = 0, fill_global = 0, lk_en = 0, lk_hit;
  logic [IDX_W-1:0] fill_idx = 0, lk_idx;

  always #4 clk = ~clk;

  xlat_inval_unit #(.ENTRIES(ENTRIES), .QDEPTH(QDEPTH), .VPN_W(VPN_W), .ID_W(ID_W)) uut (.*);

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct { bit v; int vpn, asid, vmid; bit g; } ent_t;
  typedef struct { bit byv, az; int a; bit iz; int id; } req_t;
  ent_t m_ent [ENTRIES];
  req_t mq [$];
  bit exp_hit = 0;
  int exp_idx = 0;

  function automatic bit kills(ent_t e, req_t r);
    return e.v && (r.az || e.vpn == r.a) &&
           (r.iz || (r.byv ? e.vmid == r.id : (e.asid == r.id && !e.g)));
  endfunction

  function automatic bit m_ready(int op);
    case (op)
      0: return sb_empty && mq.size() == 0 && !fill_en;
      1, 2, 3: return mq.size() < QDEPTH;
      4: return sb_empty;
      5: return mq.size() == 0;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      foreach (m_ent[i]) m_ent[i].v = 0;
      mq.delete();
      exp_hit = 0;
    end else begin
      bit acc;
      req_t r;
      exp_hit = 0;
      if (lk_en)
        for (int i = ENTRIES - 1; i >= 0; i--)
          if (m_ent[i].v && m_ent[i].vpn == int'(lk_vpn) && m_ent[i].vmid == int'(lk_vmid) &&
              (m_ent[i].g || m_ent[i].asid == int'(lk_asid))) begin
            exp_hit = 1; exp_idx = i;
          end
      acc = in_valid && m_ready(int'(in_op));
      if (mq.size() > 0 && !fill_en) begin
        r = mq.pop_front();
        foreach (m_ent[i]) if (kills(m_ent[i], r)) m_ent[i].v = 0;
      end
      if (fill_en) begin
        m_ent[fill_idx].v = 1; m_ent[fill_idx].vpn = int'(fill_vpn);
        m_ent[fill_idx].asid = int'(fill_asid); m_ent[fill_idx].vmid = int'(fill_vmid);
        m_ent[fill_idx].g = fill_global;
      end
      r.byv = (in_op == 3); r.az = in_addr_zero; r.a = int'(in_addr);
      r.iz = in_id_zero; r.id = int'(in_id);
      if (acc && in_op >= 1 && in_op <= 3) mq.push_back(r);
      if (acc && in_op == 0) foreach (m_ent[i]) if (kills(m_ent[i], r)) m_ent[i].v = 0;
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog %s actual=%0d expected=<100000", cur_req, cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " lookup hit"}, int'(lk_hit), int'(exp_hit));
      if (exp_hit) chk({cur_req, " lookup index"}, int'(lk_idx), exp_idx);
      if (in_valid) chk({cur_req, " ready"}, int'(in_ready), int'(m_ready(int'(in_op))));
    end
  end

  // tasks start and end just after a rising edge
  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic op_send(int op, bit az, int a, bit iz, int id);
    in_op = 3'(op); in_addr_zero = az; in_addr = VPN_W'(a); in_id_zero = iz; in_id = ID_W'(id);
    in_valid = 1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 0;
  endtask

  task automatic fill(int idx, int vpn, int asid, int vmid, bit g);
    fill_en = 1; fill_idx = IDX_W'(idx); fill_vpn = VPN_W'(vpn);
    fill_asid = ID_W'(asid); fill_vmid = ID_W'(vmid); fill_global = g;
    @(posedge clk); #2;
    fill_en = 0;
  endtask

  task automatic look_exp(int vpn, int asid, int vmid, int exp);
    lk_en = 1; lk_vpn = VPN_W'(vpn); lk_asid = ID_W'(asid); lk_vmid = ID_W'(vmid);
    @(posedge clk); #2;
    lk_en = 0;
    @(negedge clk);
    chk({cur_req, " directed lookup"}, int'(lk_hit), exp);
    @(posedge clk); #2;
  endtask

  task automatic fill_all();
    for (int i = 0; i < ENTRIES; i++) fill(i, 256 + i, i % 3, (i < 4) ? 1 : 2, i == 5);
  endtask

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R1: empty after reset
    cur_req = "R1";
    look_exp(256, 0, 1, 0);
    in_op = 3'd5; in_valid = 1;
    @(negedge clk); chk("R1 wait-invals ready", int'(in_ready), 1);
    @(posedge clk); #2; in_valid = 0;

    // R11 and R2: fills then lookups
    cur_req = "R11";
    fill_all();
    look_exp(256, 0, 1, 1);
    look_exp(263, 1, 2, 1);
    cur_req = "R2";
    look_exp(256, 0, 2, 0);
    look_exp(256, 1, 1, 0);
    look_exp(261, 7, 2, 1);

    // R3: address-space invalidations
    cur_req = "R3";
    op_send(1, 0, 257, 0, 1); op_send(5, 0, 0, 0, 0);
    look_exp(257, 1, 1, 0);
    look_exp(256, 0, 1, 1);
    op_send(1, 0, 258, 1, 0); op_send(5, 0, 0, 0, 0);
    look_exp(258, 2, 1, 0);
    op_send(1, 1, 0, 0, 2); op_send(5, 0, 0, 0, 0);
    look_exp(261, 0, 2, 1);
    op_send(2, 0, 259, 0, 0); op_send(5, 0, 0, 0, 0);
    look_exp(259, 0, 1, 0);

    // R4: VMID-matched invalidation ignores global
    cur_req = "R4";
    op_send(3, 1, 0, 0, 2); op_send(5, 0, 0, 0, 0);
    look_exp(261, 0, 2, 0);
    look_exp(260, 1, 2, 0);
    look_exp(256, 0, 1, 1);

    // R5, R6, R8: fill holds the queue so it fills up
    cur_req = "R5";
    fill_all();
    fork
      begin
        fill_en = 1; fill_idx = 7; fill_vpn = 263; fill_asid = 1; fill_vmid = 2; fill_global = 0;
        idle(6);
        fill_en = 0;
      end
      begin
        for (int k = 0; k < 4; k++) op_send(1, 0, 256 + k, 1, 0);
        in_op = 3'd1; in_addr_zero = 0; in_addr = 260; in_id_zero = 1; in_valid = 1;
        @(negedge clk); chk("R5 queue full stalls", int'(in_ready), 0);
        @(posedge clk); #2;
        op_send(1, 0, 260, 1, 0);
        cur_req = "R8";
        in_op = 3'd5; in_valid = 1;
        @(negedge clk); chk("R8 wait-invals stalls", int'(in_ready), 0);
        @(posedge clk); #2;
        op_send(5, 0, 0, 0, 0);
      end
      begin
        idle(6);
        cur_req = "R6";
        lk_en = 1; lk_vpn = 256; lk_asid = 0; lk_vmid = 1;
        idle(3);
        lk_en = 0;
      end
    join
    cur_req = "R8";
    look_exp(256, 0, 1, 0);
    look_exp(259, 0, 1, 0);
    look_exp(260, 1, 2, 0);
    look_exp(263, 1, 2, 1);

    // R7: wait for stores
    cur_req = "R7";
    sb_empty = 0;
    fork
      op_send(4, 0, 0, 0, 0);
      begin idle(5); sb_empty = 1; end
    join

    // R9: full fence waits, then removes ASID 0 non-global entries
    cur_req = "R9";
    fill_all();
    sb_empty = 0;
    fork
      op_send(0, 1, 0, 0, 0);
      begin idle(3); sb_empty = 1; end
    join
    look_exp(256, 0, 1, 0);
    look_exp(262, 0, 2, 0);
    look_exp(257, 1, 1, 1);
    look_exp(261, 0, 2, 1);

    // R10: undefined codes change nothing
    cur_req = "R10";
    op_send(6, 1, 0, 1, 0);
    op_send(7, 1, 0, 1, 0);
    idle(2);
    look_exp(257, 1, 1, 1);
    look_exp(263, 1, 2, 1);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule